// File: doc/BRIEF.md
# Prescaled Timer/Counter

An 8-bit up-counter that advances either once per instruction cycle or on selected edges of one of two asynchronous clock inputs: a general input pin and a sensing-oscillator input. An optional power-of-two prescaler can divide the chosen event stream. Each event, prescaled or not, passes through two instruction cycles of synchronization before it reaches the counter. The instruction cycle is a single-cycle strobe on the system clock, once every four system clocks.

Software uses a small register port with one shared address for reads and writes. It can load or read the count, program the configuration byte, and read or clear a sticky overflow flag. When the count wraps from 0xFF to 0x00, the flag is set and a one-clock pulse appears on an output, which can gate a neighbouring timer. A count write holds off counting for the two instruction cycles that follow it, so software can allow for that when it picks the value it loads.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count reads 0x00, the configuration reads 0x08 (timer mode, prescaler bypassed), the flag reads 0 and `ovfPulse` is low.
- R2: In timer mode (configuration bit 5 = 0) with the prescaler bypassed (bit 3 = 1), the count advances by exactly one every four system clocks.
- R3: With bit 3 = 0, the event stream is divided by 2^(R+1), where R is configuration bits 2:0. This gives ratios from 1:2 to 1:256, in timer mode and in counter mode alike.
- R4: In counter mode (bit 5 = 1), bit 6 picks the source: 0 for `extPin`, 1 for `senseClk`. Each qualifying edge of the picked input adds one, and edges on the other input have no effect on the count.
- R5: Bit 4 selects the counted transition: 0 counts low-to-high, 1 counts high-to-low. The opposite transition has no effect.
- R6: A write to address 0 loads the count, and reading it back returns the written value. The first increment after the write lands between 9 and 12 system clocks later, and never earlier.
- R7: A wrap from 0xFF to 0x00 sets the flag (address 2, bit 0). `ovfPulse` goes high for exactly one clock per wrap, in the clock where the count reads 0x00.
- R8: The flag stays set until a write to address 2 with bit 0 = 0 clears it. Writing bit 0 = 1 has no effect. A wrap in the same clock as a clearing write leaves the flag set.
- R9: Any write to address 0 or address 1 empties the prescaler, so events seen before the write do not count toward the next prescaled step.
- R10: Address 3 reads 0x00 and writes to it change nothing. Configuration bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | Asynchronous external count input |
| senseClk | input | 1 | Asynchronous sensing-oscillator count input |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write (0 count, 1 configuration, 2 status, 3 unused) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `regAddr`, combinational |
| ovfPulse | output | 1 | One-clock pulse on each wrap from 0xFF to 0x00 |

## Verification
The bench builds the block with its default parameters: a divide-by-four instruction cycle, two-flop input synchronizers, two instruction cycles of event synchronization and two cycles of write inhibit. With a period of only four clocks per step, the bench can sweep all eight prescale ratios and observe full wraps at 1:1 within a few thousand clocks. Eight count writes at staggered clock offsets cover every phase of the divider relative to the write, which checks the 9-to-12-clock window for the first increment.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int RATIO_W = 3;
  localparam int DATA_W  = 8;

  // configuration byte bits 6:0; bit 7 reads as zero
  typedef struct packed {
    logic               sensSel;    // bit 6: 1 = sensing-oscillator input
    logic               cntMode;    // bit 5: 1 = count external edges
    logic               fallEdge;   // bit 4: 1 = high-to-low transitions
    logic               preBypass;  // bit 3: 1 = prescaler bypassed
    logic [RATIO_W-1:0] ratio;      // bits 2:0: divide by 2^(ratio+1)
  } cfg_t;

  localparam cfg_t CFG_RESET = '{sensSel: 1'b0, cntMode: 1'b0, fallEdge: 1'b0,
                                 preBypass: 1'b1, ratio: '0};

  typedef enum logic [1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_CFG   = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_NONE  = 2'd3
  } regAddr_e;

  // datapath -> control: register write events
  typedef struct packed {
    logic cntWrite;
    logic cfgWrite;
  } regEvt_t;

  // control -> datapath: count strobe
  typedef struct packed {
    logic incEn;
  } cntStb_t;

endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int CYC_DIV     = 4,
  parameter int SYNC_FF     = 2,
  parameter int SYNC_TCY    = 2,
  parameter int INHIBIT_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    extPin,
  input  logic    senseClk,
  input  cfg_t    cfg,
  input  regEvt_t regEvt,
  output cntStb_t cntStb
);

  localparam int DIV_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam int PRE_W = 1 << RATIO_W;
  localparam int INH_W = $clog2(INHIBIT_CYC + 1);
  localparam int N_IN  = 2;

  // instruction-cycle strobe
  logic [DIV_W-1:0] divCnt;
  logic cycStrobe;

  assign cycStrobe = (divCnt == DIV_W'(CYC_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (cycStrobe) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // per-input synchronizer and edge detector
  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] riseIn;
  logic [N_IN-1:0] fallIn;

  assign rawIn = {senseClk, extPin};

  for (genvar g = 0; g < N_IN; g++) begin : gSync
    logic [SYNC_FF-1:0] chain;
    logic prevLvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain   <= '0;
        prevLvl <= 1'b0;
      end else begin
        chain   <= {chain[SYNC_FF-2:0], rawIn[g]};
        prevLvl <= chain[SYNC_FF-1];
      end
    end
    assign riseIn[g] = chain[SYNC_FF-1] & ~prevLvl;
    assign fallIn[g] = ~chain[SYNC_FF-1] & prevLvl;
  end

  logic selIdx;
  logic extEdge;
  logic rawEvent;

  assign selIdx   = cfg.sensSel;
  assign extEdge  = cfg.fallEdge ? fallIn[selIdx] : riseIn[selIdx];
  assign rawEvent = cfg.cntMode ? extEdge : cycStrobe;

  // prescaler
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic preHit;
  logic tick;
  logic regTouch;

  assign regTouch = regEvt.cntWrite | regEvt.cfgWrite;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) preMask[i] = (i <= int'(cfg.ratio));
  end

  assign preHit = rawEvent && ((preCnt & preMask) == preMask);
  assign tick   = cfg.preBypass ? rawEvent : preHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (regTouch) preCnt <= '0;
    else if (rawEvent) preCnt <= preHit ? '0 : preCnt + 1'b1;
  end

  // instruction-cycle synchronizer of the count events
  logic pending;
  logic [SYNC_TCY-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      stage   <= '0;
    end else if (regTouch) begin
      pending <= 1'b0;
      stage   <= '0;
    end else if (cycStrobe) begin
      pending <= 1'b0;
      stage   <= {stage[SYNC_TCY-2:0], pending | tick};
    end else begin
      pending <= pending | tick;
    end
  end

  // post-write inhibit
  logic [INH_W-1:0] inhCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inhCnt <= '0;
    else if (regEvt.cntWrite) inhCnt <= INH_W'(INHIBIT_CYC);
    else if (cycStrobe && inhCnt != '0) inhCnt <= inhCnt - 1'b1;
  end

  assign cntStb.incEn = cycStrobe && stage[SYNC_TCY-1] && (inhCnt == '0)
                        && !regEvt.cntWrite;

endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  cntStb_t           cntStb,
  output logic [DATA_W-1:0] rdData,
  output cfg_t              cfg,
  output regEvt_t           regEvt,
  output logic [DATA_W-1:0] countQ,
  output logic              flagQ,
  output logic              ovfPulse
);

  localparam int CFG_BITS = $bits(cfg_t);

  logic stsClear;
  logic wrapNow;

  assign regEvt.cntWrite = wrEn && (regAddr == ADDR_COUNT);
  assign regEvt.cfgWrite = wrEn && (regAddr == ADDR_CFG);
  assign stsClear        = wrEn && (regAddr == ADDR_STAT) && !wrData[0];
  assign wrapNow         = cntStb.incEn && !regEvt.cntWrite && (countQ == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else if (regEvt.cntWrite) countQ <= wrData;
    else if (cntStb.incEn) countQ <= countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= CFG_RESET;
    else if (regEvt.cfgWrite) cfg <= cfg_t'(wrData[CFG_BITS-1:0]);
  end

  // a wrap in the same clock as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 1'b0;
    else if (wrapNow) flagQ <= 1'b1;
    else if (stsClear) flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfPulse <= 1'b0;
    else ovfPulse <= wrapNow;
  end

  always_comb begin
    case (regAddr)
      ADDR_COUNT: rdData = countQ;
      ADDR_CFG:   rdData = DATA_W'(cfg);
      ADDR_STAT:  rdData = {{(DATA_W-1){1'b0}}, flagQ};
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CYC_DIV     = 4,
  parameter int SYNC_FF     = 2,
  parameter int SYNC_TCY    = 2,
  parameter int INHIBIT_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extPin,
  input  logic       senseClk,
  input  logic       wrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       ovfPulse
);

  ptmr_pkg::cfg_t    cfg;
  ptmr_pkg::regEvt_t regEvt;
  ptmr_pkg::cntStb_t cntStb;
  logic [7:0] countQ;
  logic       flagQ;

  ptmr_ctrl #(
    .CYC_DIV    (CYC_DIV),
    .SYNC_FF    (SYNC_FF),
    .SYNC_TCY   (SYNC_TCY),
    .INHIBIT_CYC(INHIBIT_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .extPin  (extPin),
    .senseClk(senseClk),
    .cfg     (cfg),
    .regEvt  (regEvt),
    .cntStb  (cntStb)
  );

  ptmr_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .cntStb  (cntStb),
    .rdData  (rdData),
    .cfg     (cfg),
    .regEvt  (regEvt),
    .countQ  (countQ),
    .flagQ   (flagQ),
    .ovfPulse(ovfPulse)
  );

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ovfPulse,
  input logic       cntWrite,
  input logic       flagQ,
  input logic [7:0] countQ,
  input logic       wrEn,
  input logic [1:0] regAddr,
  input logic [7:0] wrData
);

  logic       pastValid;
  logic [3:0] wrAge;
  logic       clrReq;

  assign clrReq = wrEn && (regAddr == 2'd2) && !wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else pastValid <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrAge <= 4'hF;
    else if (cntWrite) wrAge <= 4'd0;
    else if (wrAge != 4'hF) wrAge <= wrAge + 4'd1;
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(cntWrite) && (countQ != $past(countQ)))
      |-> (countQ == 8'($past(countQ) + 8'd1))); // R2

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrAge <= 4'd7 && !cntWrite) |=> $stable(countQ)); // R6

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse); // R7

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> flagQ); // R7

  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (countQ == 8'd0)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrReq) |=> flagQ); // R8

endmodule

bind prescaled_timer ptmr_checker u_ptmrChecker (
  .clk     (clk),
  .rstN    (rstN),
  .ovfPulse(ovfPulse),
  .cntWrite(regEvt.cntWrite),
  .flagQ   (flagQ),
  .countQ  (countQ),
  .wrEn    (wrEn),
  .regAddr (regAddr),
  .wrData  (wrData)
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extPin = 1'b0;
  logic       senseClk = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       ovfPulse;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prescaled_timer i_prescaled_timer (
    .clk     (clk),
    .rstN    (rstN),
    .extPin  (extPin),
    .senseClk(senseClk),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .ovfPulse(ovfPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    wrData  = d;
    wrEn    = 1'b1;
    @(negedge clk);
    wrEn    = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic pulses(input bit onSense, input int n);
    for (int i = 0; i < n; i++) begin
      if (onSense) senseClk = 1'b1; else extPin = 1'b1;
      waitClk(8);
      if (onSense) senseClk = 1'b0; else extPin = 1'b0;
      waitClk(8);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int v;
    int c1;
    int c2;
    int n;
    int highs;
    int zeroAtPulse;

    waitClk(5);
    rstN = 1'b1;
    // R1: state right after reset release
    readReg(2'd0, v); chk("R1 count", v, 0);
    readReg(2'd1, v); chk("R1 config", v, 8'h08);
    readReg(2'd2, v); chk("R1 flag", v, 0);
    chk("R1 ovfPulse", int'(ovfPulse), 0);

    // R2: timer mode, prescaler bypassed
    writeReg(2'd0, 8'h10);
    waitClk(20);
    readReg(2'd0, c1);
    waitClk(200);
    readReg(2'd0, c2);
    chk("R2 step per 4 clocks", (c2 - c1) & 255, 50);

    // R6: first increment after a count write, swept over divider phases
    for (int off = 0; off < 8; off++) begin
      waitClk(off + 5);
      writeReg(2'd0, 8'(8'h30 + off * 7));
      readReg(2'd0, v);
      chk("R6 readback", v, 8'h30 + off * 7);
      n = 0;
      while (v == 8'h30 + off * 7 && n < 40) begin
        waitClk(1);
        n++;
        readReg(2'd0, v);
      end
      chkRange("R6 first increment delay", n, 9, 12);
      chk("R6 first increment value", v, 8'h31 + off * 7);
    end

    // R3: prescale sweep in timer mode
    for (int ps = 0; ps < 8; ps++) begin
      int p;
      p = 1 << (ps + 1);
      writeReg(2'd1, 8'(ps));
      writeReg(2'd0, 8'h00);
      waitClk(8 * p + 20);
      readReg(2'd0, c1);
      waitClk(12 * p);
      readReg(2'd0, c2);
      chk($sformatf("R3 timer ratio ps=%0d", ps), (c2 - c1) & 255, 3);
    end

    // R7: overflow flag and pulse
    writeReg(2'd1, 8'h08);
    writeReg(2'd2, 8'h00);
    writeReg(2'd0, 8'hFD);
    regAddr = 2'd0;
    highs = 0;
    zeroAtPulse = 1;
    for (int i = 0; i < 40; i++) begin
      waitClk(1);
      #1;
      if (ovfPulse) begin
        highs++;
        if (rdData != 8'h00) zeroAtPulse = 0;
      end
    end
    chk("R7 pulse cycles per wrap", highs, 1);
    chk("R7 count zero at pulse", zeroAtPulse, 1);
    readReg(2'd2, v); chk("R7 flag set", v, 1);

    // R8: write 1 keeps, write 0 clears
    writeReg(2'd2, 8'h01);
    readReg(2'd2, v); chk("R8 write one no effect", v, 1);
    writeReg(2'd2, 8'hFE);
    readReg(2'd2, v); chk("R8 clear by zero", v, 0);

    // R7: two wraps in 2048 clocks at 1:1
    highs = 0;
    for (int i = 0; i < 2048; i++) begin
      waitClk(1);
      if (ovfPulse) highs++;
    end
    chk("R7 wraps in window", highs, 2);
    readReg(2'd2, v); chk("R8 flag set again", v, 1);

    // R4: counter mode, pin selected, rising edges
    writeReg(2'd1, 8'h28);
    writeReg(2'd0, 8'h00);
    waitClk(20);
    pulses(1'b0, 5);
    waitClk(40);
    readReg(2'd0, v); chk("R4 pin edges counted", v, 5);
    pulses(1'b1, 3);
    waitClk(40);
    readReg(2'd0, v); chk("R4 sense input ignored", v, 5);

    // R4: sensing-oscillator input selected
    writeReg(2'd1, 8'h68);
    writeReg(2'd0, 8'h00);
    waitClk(20);
    pulses(1'b1, 4);
    waitClk(40);
    readReg(2'd0, v); chk("R4 sense edges counted", v, 4);
    pulses(1'b0, 2);
    waitClk(40);
    readReg(2'd0, v); chk("R4 pin ignored", v, 4);

    // R5: falling edges only
    writeReg(2'd1, 8'h38);
    writeReg(2'd0, 8'h00);
    waitClk(20);
    extPin = 1'b1;
    waitClk(40);
    readReg(2'd0, v); chk("R5 rise ignored in falling mode", v, 0);
    extPin = 1'b0;
    waitClk(40);
    readReg(2'd0, v); chk("R5 fall counted", v, 1);

    // R5: rising edges only
    writeReg(2'd1, 8'h28);
    writeReg(2'd0, 8'h00);
    waitClk(20);
    extPin = 1'b1;
    waitClk(40);
    readReg(2'd0, v); chk("R5 rise counted", v, 1);
    extPin = 1'b0;
    waitClk(40);
    readReg(2'd0, v); chk("R5 fall ignored in rising mode", v, 1);

    // R3: prescaled counter mode, ratio 1:8
    writeReg(2'd1, 8'h22);
    writeReg(2'd0, 8'h00);
    waitClk(20);
    pulses(1'b0, 20);
    waitClk(40);
    readReg(2'd0, v); chk("R3 counter ratio 1:8", v, 2);

    // R9: prescaler emptied by register writes, ratio 1:2
    writeReg(2'd1, 8'h20);
    writeReg(2'd0, 8'h00);
    waitClk(20);
    pulses(1'b0, 1);
    waitClk(40);
    readReg(2'd0, v); chk("R9 half step pending", v, 0);
    writeReg(2'd1, 8'h20);
    waitClk(20);
    pulses(1'b0, 1);
    waitClk(40);
    readReg(2'd0, v); chk("R9 config write empties prescaler", v, 0);
    pulses(1'b0, 1);
    waitClk(40);
    readReg(2'd0, v); chk("R9 second edge steps", v, 1);
    pulses(1'b0, 1);
    waitClk(40);
    writeReg(2'd0, 8'h40);
    waitClk(20);
    pulses(1'b0, 1);
    waitClk(40);
    readReg(2'd0, v); chk("R9 count write empties prescaler", v, 8'h40);
    pulses(1'b0, 1);
    waitClk(40);
    readReg(2'd0, v); chk("R9 step after count write", v, 8'h41);

    // R10: unused address and spare bit
    writeReg(2'd3, 8'hFF);
    readReg(2'd3, v); chk("R10 unused address reads zero", v, 0);
    readReg(2'd1, v); chk("R10 config untouched", v, 8'h20);
    readReg(2'd0, v); chk("R10 count untouched", v, 8'h41);
    readReg(2'd2, v); chk("R10 flag untouched", v, 1);
    writeReg(2'd1, 8'hFF);
    readReg(2'd1, v); chk("R10 spare bit reads zero", v, 8'h7F);

    finished = 1'b1;
    report();
  end

endmodule